// File: doc/BRIEF.md
# Saturating Narrowing Shift Right Unit

This unit narrows a packed vector. The source vector is cut into wide lanes. Each lane is shifted right by an immediate amount, can be rounded to nearest, and is then clamped into a lane of half its width. The narrowed lanes are packed into a result that is half as wide as the source. A run-time size select sets the destination lane width to 8, 16 or 32 bits. The source lanes are twice that width.

Two selects set how the data is read and clamped. One says whether the source is signed. The other says whether the destination is signed. Three combinations are meaningful: signed to signed, signed to unsigned, and unsigned to unsigned. The shift immediate is stored inverted: the field is subtracted from the destination width. A sticky flag records that at least one lane of some issued operation was clamped. The flag holds its value until software or the surrounding pipeline clears it.

Each operation is presented with a one-cycle issue strobe. The result and its valid bit are registered and appear on the following cycle. There is no back-pressure.

Top module: `nsr_unit`

## Requirements
- R1: The right-shift amount is e minus the field value, where e is the destination width and the field is taken modulo e (only its low log2(e) bits are used). The amount therefore lies between 1 and e.
- R2: When round_en is 1, 2^(shift-1) is added to the extended source lane before the shift. The carry out of the lane width is kept, including for 64-bit source lanes.
- R3: A signed source lane is sign-extended and shifted arithmetically. An unsigned source lane is zero-extended and shifted logically.
- R4: With a signed source and a signed destination, the shifted value is clamped to the range from -2^(e-1) to 2^(e-1)-1.
- R5: With an unsigned destination, the shifted value is clamped to the range from 0 to 2^e-1. A negative signed source therefore gives 0.
- R6: When src_signed is 0, dst_signed has no effect, and the operation runs as unsigned to unsigned.
- R7: dst_size selects the destination width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Narrowed lane i occupies res_vec bits [i*e +: e], and there are VEC_W/(2e) lanes.
- R8: sat_flag becomes 1 in the cycle after an issued operation clamps any lane. It then stays 1 until it is cleared.
- R9: sat_clear with no issue drives sat_flag to 0 on the next cycle. A sat_clear in the same cycle as an issued operation that clamps leaves sat_flag at 1.
- R10: res_vec and res_valid change one cycle after issue. When issue is 0, res_vec holds its value and res_valid is 0.
- R11: While rst is 1, res_vec, res_valid and sat_flag are all 0 (synchronous reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Starts one operation on the current inputs |
| src_vec | input | VEC_W | Packed wide source lanes |
| dst_size | input | 2 | Destination width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| shf_field | input | 5 | Inverted shift immediate |
| round_en | input | 1 | Adds the rounding constant before the shift |
| src_signed | input | 1 | The source lanes are signed |
| dst_signed | input | 1 | The destination is signed (used only when src_signed is 1) |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| res_vec | output | VEC_W/2 | Packed narrowed result, registered |
| res_valid | output | 1 | res_vec was updated by the previous cycle's issue |
| sat_flag | output | 1 | Sticky indication that a lane was clamped |

## Verification
The sticky flag's clear and a new clamping operation can both land on the same clock edge. The bench provokes this in two ways. It drives sat_clear together with an issued op whose lanes saturate, and expects the flag to remain set. It drives sat_clear together with an issued op that stays in range, and expects the flag to drop. A clear on a cycle with no issue is checked separately, as is a saturating op followed by a non-saturating one, which must leave the flag set.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  // Destination lane width encodings
  typedef enum logic [1:0] {
    DSZ_8   = 2'd0,
    DSZ_16  = 2'd1,
    DSZ_32  = 2'd2,
    DSZ_32B = 2'd3
  } dst_size_e;

  localparam int NSR_NUM_SIZES = 3;
  localparam int NSR_MIN_DST_W = 8;
  localparam int NSR_MAX_DST_W = NSR_MIN_DST_W << (NSR_NUM_SIZES - 1);
  localparam int NSR_FLD_W     = $clog2(NSR_MAX_DST_W);

  // Maps the size code onto the index of the bank that serves it
  function automatic int unsigned bank_of(input logic [1:0] code);
    case (code)
      DSZ_8:   return 0;
      DSZ_16:  return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/nsr_lane.sv
module nsr_lane #(
  parameter int SRC_W = 16
) (
  input  logic [SRC_W-1:0]                lane_in,
  input  logic [$clog2(SRC_W/2)-1:0]      fld,
  input  logic                            rnd,
  input  logic                            src_sgn,
  input  logic                            dst_sgn,
  output logic [SRC_W/2-1:0]              nar,
  output logic                            clamped
);
  localparam int E   = SRC_W / 2;
  localparam int SHW = $clog2(E) + 1;
  localparam int EXT = SRC_W + 2;

  localparam logic signed [EXT-1:0] HI_S = (EXT'(1) << (E - 1)) - EXT'(1);
  localparam logic signed [EXT-1:0] LO_S = ~HI_S;
  localparam logic signed [EXT-1:0] HI_U = (EXT'(1) << E) - EXT'(1);
  localparam logic signed [EXT-1:0] LO_U = '0;

  logic [SHW-1:0]          sh;
  logic signed [EXT-1:0]   ext_v;
  logic signed [EXT-1:0]   rnd_c;
  logic signed [EXT-1:0]   sum_v;
  logic signed [EXT-1:0]   shr_v;
  logic signed [EXT-1:0]   hi_v;
  logic signed [EXT-1:0]   lo_v;
  logic                    signed_out;
  logic                    over;
  logic                    under;

  // The field holds the inverted amount: shift = E - field, range 1..E
  assign sh = SHW'(E) - SHW'(fld);

  // Two guard bits hold the sign and the rounding carry
  assign ext_v = {{2{src_sgn & lane_in[SRC_W-1]}}, lane_in};
  assign rnd_c = rnd ? EXT'(EXT'(1) << (sh - SHW'(1))) : '0;
  assign sum_v = ext_v + rnd_c;
  assign shr_v = sum_v >>> sh;

  // An unsigned source always narrows into an unsigned destination
  assign signed_out = src_sgn & dst_sgn;
  assign hi_v  = signed_out ? HI_S : HI_U;
  assign lo_v  = signed_out ? LO_S : LO_U;
  assign over  = shr_v > hi_v;
  assign under = shr_v < lo_v;

  always_comb begin
    if (over)       nar = hi_v[E-1:0];
    else if (under) nar = lo_v[E-1:0];
    else            nar = shr_v[E-1:0];
  end

  assign clamped = over | under;

endmodule

// File: rtl/nsr_bank.sv
module nsr_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic [VEC_W-1:0]              src,
  input  logic [$clog2(LANE_W/2)-1:0]   fld,
  input  logic                          rnd,
  input  logic                          src_sgn,
  input  logic                          dst_sgn,
  output logic [VEC_W/2-1:0]            res,
  output logic                          any_clamp
);
  localparam int NLANE = VEC_W / LANE_W;
  localparam int E     = LANE_W / 2;

  logic [NLANE-1:0] lane_clamp;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    nsr_lane #(.SRC_W(LANE_W)) i_lane (
      .lane_in (src[i*LANE_W +: LANE_W]),
      .fld     (fld),
      .rnd     (rnd),
      .src_sgn (src_sgn),
      .dst_sgn (dst_sgn),
      .nar     (res[i*E +: E]),
      .clamped (lane_clamp[i])
    );
  end

  assign any_clamp = |lane_clamp;

endmodule

// File: rtl/nsr_unit.sv
module nsr_unit #(
  parameter int VEC_W = 128
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          issue,
  input  logic [VEC_W-1:0]              src_vec,
  input  logic [1:0]                    dst_size,
  input  logic [nsr_pkg::NSR_FLD_W-1:0] shf_field,
  input  logic                          round_en,
  input  logic                          src_signed,
  input  logic                          dst_signed,
  input  logic                          sat_clear,
  output logic [VEC_W/2-1:0]            res_vec,
  output logic                          res_valid,
  output logic                          sat_flag
);
  import nsr_pkg::*;

  localparam int RES_W = VEC_W / 2;

  logic [RES_W-1:0]         bank_res   [NSR_NUM_SIZES];
  logic [NSR_NUM_SIZES-1:0] bank_clamp;
  logic [RES_W-1:0]         sel_res;
  logic                     sel_clamp;
  logic [RES_W-1:0]         res_q;
  logic                     vld_q;
  logic                     sat_q;

  // One bank per destination width; all evaluate, one is chosen
  for (genvar g = 0; g < NSR_NUM_SIZES; g++) begin : g_bank
    localparam int LW = (2 * NSR_MIN_DST_W) << g;
    localparam int FW = $clog2(LW / 2);
    nsr_bank #(.VEC_W(VEC_W), .LANE_W(LW)) i_bank (
      .src       (src_vec),
      .fld       (shf_field[FW-1:0]),
      .rnd       (round_en),
      .src_sgn   (src_signed),
      .dst_sgn   (dst_signed),
      .res       (bank_res[g]),
      .any_clamp (bank_clamp[g])
    );
  end

  always_comb begin
    sel_res   = bank_res[bank_of(dst_size)];
    sel_clamp = bank_clamp[bank_of(dst_size)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      vld_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      vld_q <= issue;
      if (issue) res_q <= sel_res;
      // A clamp in the clearing cycle wins over the clear
      sat_q <= (sat_q & ~sat_clear) | (issue & sel_clamp);
    end
  end

  assign res_vec   = res_q;
  assign res_valid = vld_q;
  assign sat_flag  = sat_q;

endmodule

// File: rtl/nsr_unit_chk.sv
module nsr_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               issue,
  input logic               sat_clear,
  input logic [VEC_W/2-1:0] res_vec,
  input logic               res_valid,
  input logic               sat_flag
);

  // R10
  res_valid_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> res_valid);

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |=> ($stable(res_vec) && !res_valid));

  // R8
  sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clear) |=> sat_flag);

  // R8
  sat_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> $past(issue));

  // R9
  sat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_clear && !issue) |=> !sat_flag);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && !sat_flag && res_vec == '0));

endmodule

bind nsr_unit nsr_unit_chk #(.VEC_W(VEC_W)) i_nsr_unit_chk (
  .clk       (clk),
  .rst       (rst),
  .issue     (issue),
  .sat_clear (sat_clear),
  .res_vec   (res_vec),
  .res_valid (res_valid),
  .sat_flag  (sat_flag)
);

// File: tb/test_nsr_unit.sv
module test_nsr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;

  typedef struct {
    logic [63:0] res;
    bit          sat;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issue = 1'b0;
  logic [VW-1:0] src_vec = '0;
  logic [1:0]    dst_size = '0;
  logic [4:0]    shf_field = '0;
  logic          round_en = 1'b0;
  logic          src_signed = 1'b0;
  logic          dst_signed = 1'b0;
  logic          sat_clear = 1'b0;
  logic [63:0]   res_vec;
  logic          res_valid;
  logic          sat_flag;

  int    checks = 0;
  int    errors = 0;
  bit    sticky_exp = 1'b0;
  logic [63:0] last_res = '0;
  exp_t  sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nsr_unit #(.VEC_W(VW)) i_nsr_unit (
    .clk(clk), .rst(rst), .issue(issue), .src_vec(src_vec),
    .dst_size(dst_size), .shf_field(shf_field), .round_en(round_en),
    .src_signed(src_signed), .dst_signed(dst_signed), .sat_clear(sat_clear),
    .res_vec(res_vec), .res_valid(res_valid), .sat_flag(sat_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Independent model of the narrowing for a 128-bit source
  function automatic logic [63:0] model(input logic [127:0] s, input int dsz, input int fld,
                                        input bit rnd, input bit ss, input bit ds, output bit sat);
    int e, w, n, sh;
    logic [63:0] r, lb, m64;
    logic signed [67:0] v, hi, lo;
    e  = (dsz == 0) ? 8 : (dsz == 1) ? 16 : 32;
    w  = 2 * e;
    n  = 128 / w;
    sh = e - (fld % e);
    r = '0;
    sat = 1'b0;
    m64 = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < n; i++) begin
      lb = 64'(s >> (i * w)) & m64;
      v  = {4'b0, lb};
      if (ss && lb[w-1]) v = v - (68'd1 << w);
      if (rnd) v = v + (68'd1 << (sh - 1));
      v = v >>> sh;
      if (ss && ds) begin
        hi = (68'sd1 <<< (e - 1)) - 68'sd1;
        lo = -(68'sd1 <<< (e - 1));
      end else begin
        hi = (68'sd1 <<< e) - 68'sd1;
        lo = '0;
      end
      if (v > hi) begin v = hi; sat = 1'b1; end
      else if (v < lo) begin v = lo; sat = 1'b1; end
      r = r | ((64'(v) & ((64'd1 << e) - 64'd1)) << (i * e));
    end
    return r;
  endfunction

  // Driver: applies one issued op and pushes what the monitor must see
  task automatic op(input logic [127:0] s, input int dsz, input int fld, input bit rnd,
                    input bit ss, input bit ds, input bit clr,
                    input logic [63:0] exp_res, input bit exp_clamp, input string tag);
    exp_t it;
    @(negedge clk);
    src_vec = s; dst_size = 2'(dsz); shf_field = 5'(fld);
    round_en = rnd; src_signed = ss; dst_signed = ds;
    sat_clear = clr; issue = 1'b1;
    sticky_exp = (clr ? 1'b0 : sticky_exp) | exp_clamp;
    it.res = exp_res; it.sat = sticky_exp; it.tag = tag;
    sb_q.push_back(it);
    last_res = exp_res;
  endtask

  task automatic opm(input logic [127:0] s, input int dsz, input int fld, input bit rnd,
                     input bit ss, input bit ds, input bit clr, input string tag);
    bit c;
    logic [63:0] r;
    r = model(s, dsz, fld, rnd, ss, ds, c);
    op(s, dsz, fld, rnd, ss, ds, clr, r, c, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    issue = 1'b0;
    sat_clear = 1'b0;
  endtask

  // Monitor: compares each produced result against the queue head
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (res_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R10 unexpected result", res_vec, 64'd0);
        end else begin
          it = sb_q.pop_front();
          chk(res_vec == it.res, it.tag, res_vec, it.res);
          chk(sat_flag == it.sat, {it.tag, " R8 flag"}, 64'(sat_flag), 64'(it.sat));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(res_vec == '0, "R11 res", res_vec, 64'd0);
    chk(res_valid == 1'b0, "R11 valid", 64'(res_valid), 64'd0);
    chk(sat_flag == 1'b0, "R11 flag", 64'(sat_flag), 64'd0);

    // R2 rounding at 32-bit destination, carry into upper half
    op({64'h00000001_00000000, 64'hFFFFFFFE_80000000}, 2, 0, 1, 0, 0, 0,
       64'h00000001_FFFFFFFF, 0, "R2 round 32");
    // R7 packing order with 16-bit lanes
    op({32'h0004_0000, 32'h0003_0000, 32'h0002_0000, 32'h0001_0000}, 1, 0, 0, 0, 0, 0,
       64'h0004_0003_0002_0001, 0, "R7 pack");
    // R1 field 9 on 8-bit lanes acts as 1, shift 7
    op({8{16'h0100}}, 0, 9, 0, 0, 0, 0, 64'h0202020202020202, 0, "R1 field modulo");
    // R2 rounding on 8-bit lanes: (5+1)>>1
    op({8{16'h0005}}, 0, 7, 1, 0, 0, 0, 64'h0303030303030303, 0, "R2 round 8");
    // R3 arithmetic shift of a signed lane
    op({8{16'hFFFE}}, 0, 7, 0, 1, 1, 0, 64'hFFFFFFFFFFFFFFFF, 0, "R3 signed shift");
    op({8{16'hC000}}, 0, 0, 0, 1, 1, 0, 64'hC0C0C0C0C0C0C0C0, 0, "R3 signed shift 8");
    // R3 logical shift of the same bits saturates
    op({8{16'hFFFE}}, 0, 7, 0, 0, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, "R3 unsigned shift");
    // R8 flag stays set through a non-clamping op
    op({8{16'h0100}}, 0, 9, 0, 0, 0, 0, 64'h0202020202020202, 0, "R8 sticky hold");
    // R9 clear with no issue
    @(negedge clk);
    issue = 1'b0; sat_clear = 1'b1; sticky_exp = 1'b0;
    @(negedge clk);
    sat_clear = 1'b0;
    chk(sat_flag == 1'b0, "R9 clear alone", 64'(sat_flag), 64'd0);
    // R4 signed clamp both ways
    op({4{32'h8000_7FFF}}, 0, 7, 0, 1, 1, 0, 64'h807F807F807F807F, 1, "R4 signed clamp");
    // R9 clear together with clamping op: R5 negative to unsigned gives 0
    op({8{16'hFFFE}}, 0, 7, 0, 1, 0, 1, 64'h0, 1, "R5 R9 clear with clamp");
    // R9 clear together with in-range op
    op({8{16'h0005}}, 0, 7, 1, 0, 0, 1, 64'h0303030303030303, 0, "R9 clear no clamp");
    // R6 dst_signed ignored for unsigned source
    op({8{16'h8000}}, 0, 7, 0, 0, 1, 0, 64'hFFFFFFFFFFFFFFFF, 1, "R6 unsigned source");
    // R7 size code 3 acts as 32
    op({64'h00000007_00000000, 64'h00000005_00000000}, 3, 0, 0, 0, 0, 0,
       64'h00000007_00000005, 0, "R7 size code 3");
    // R2 carry out at 64-bit lanes
    op({128{1'b1}}, 2, 0, 1, 0, 0, 0, 64'hFFFFFFFFFFFFFFFF, 1, "R2 carry 64");

    // Mixed patterns through the model, sizes and modes rotating
    for (int k = 0; k < 60; k++) begin
      logic [127:0] s;
      int md;
      s = {$urandom, $urandom, $urandom, $urandom};
      md = k % 3;
      opm(s, k % 4, int'($urandom % 32), bit'(k[2]), md != 2, md == 0, k % 7 == 0,
          "R1 R3 R4 R5 mixed");
    end

    // R10 hold while idle
    idle();
    idle();
    idle();
    chk(res_valid == 1'b0, "R10 idle valid", 64'(res_valid), 64'd0);
    chk(res_vec == last_res, "R10 hold", res_vec, last_res);
    chk(sb_q.size() == 0, "R10 all results seen", 64'(sb_q.size()), 64'd0);
    report();
  end

endmodule